// File: doc/BRIEF.md
# Operation-FIFO SPI Flash Sequencer

This block is a single-lane SPI master for serial flash memories. Software does not hand it a fixed command/address/data frame. It writes a stream of small operation words into an operation FIFO. Each word holds a 5-bit opcode and a 9-bit byte count. One operation drives chip select low or high. Another shifts bytes out of a transmit data FIFO. A third shifts bytes in and stores them in a receive data FIFO. A flash command is therefore a short program: select, opcode byte, address bytes, dummy bytes (sent as 0xFF), data, deselect.

The engine takes one operation at a time from the FIFO and runs it to the end before it takes the next. The bus uses SPI mode 0. SCLK idles low. MOSI changes on the falling edge, MISO is sampled on the rising edge, and the MSB goes first. SCLK is the system clock divided by a value software programs. An output operation waits with SCLK low while the transmit FIFO has no byte. An input operation waits while the receive FIFO is full. The operation-FIFO empty flag stays low until the last operation has completed on the bus, so software can poll that flag to detect completion.

Top module: `spi_opseq`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, op_empty is 1, op_full is 0, tx_full is 0 and rx_empty is 1.
- R2: The operation word is staged by a write to address 0, with the byte count in bits 8:0 and the opcode in bits 13:9. A write with bit 0 set to address 1 pushes the staged word. Address 2 reads the full flag and address 3 reads the empty flag, each in bit 0. Read data appears on bus_rdata one cycle after the read strobe.
- R3: Opcode 0 drives spi_cs_n high and opcode 1 drives it low. Chip select changes only while SCLK is low.
- R4: Opcodes 0x08 and 0x11 each shift out count bytes, taken in order from the transmit FIFO (written at address 4, bits 7:0). Data is sent MSB first, and MOSI is stable at each SCLK rising edge.
- R5: Opcode 0x0C shifts in count bytes, MSB first, sampled on the SCLK rising edge, and pushes each byte into the receive FIFO. MOSI is held high during these bytes.
- R6: Address 6 reads the head byte of the receive FIFO. A write with bit 0 set to address 7 removes that byte. Address 8, bit 0, and the rx_empty port show that the FIFO is empty.
- R7: op_empty rises only after the last operation taken from the FIFO has completed on the bus. SCLK is low whenever op_empty is 1.
- R8: An output operation with an empty transmit FIFO waits with SCLK low. An input operation with a full receive FIFO waits without losing data. Both continue when the condition clears.
- R9: Each SCLK high phase and each SCLK low phase inside a byte lasts DIV+1 system clocks, where DIV is written at address 9.
- R10: A data operation with count 0, and any opcode not listed above, completes without SCLK activity and without any change to chip select.
- R11: A push to a full operation FIFO, or a byte write to a full transmit FIFO (tx_full at 1 after 16 bytes), is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, one cycle after bus_rd |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| op_full | output | 1 | Operation FIFO full |
| op_empty | output | 1 | Operation FIFO empty and engine idle |
| tx_full | output | 1 | Transmit FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |

## Verification
Register reads return data one cycle after the strobe. The bench therefore drives each strobe at a falling edge and samples bus_rdata at the next falling edge. A byte takes 16·(DIV+1) system clocks after the engine starts it, so the bench does not count a fixed latency. It polls op_empty at falling edges and compares the bytes seen and returned only after that flag has risen. Stall behaviour and the SCLK phase length are sampled once per system clock at the falling edge. Because spi_sclk changes only on rising edges, the number of samples taken during a phase equals the phase length.

// File: rtl/spi_opseq_pkg.sv
package spi_opseq_pkg;
   localparam int OPC_W  = 5;
   localparam int LEN_W  = 9;
   localparam int BYTE_W = 8;

   localparam logic [OPC_W-1:0] OPC_CS_HIGH = 5'h00;
   localparam logic [OPC_W-1:0] OPC_CS_LOW  = 5'h01;
   localparam logic [OPC_W-1:0] OPC_OUT     = 5'h08;
   localparam logic [OPC_W-1:0] OPC_IN      = 5'h0C;
   localparam logic [OPC_W-1:0] OPC_OUT_ALT = 5'h11;

   localparam int A_OP_STAGE = 0;
   localparam int A_OP_PUSH  = 1;
   localparam int A_OP_FULL  = 2;
   localparam int A_OP_EMPTY = 3;
   localparam int A_TX_DATA  = 4;
   localparam int A_TX_FULL  = 5;
   localparam int A_RX_DATA  = 6;
   localparam int A_RX_POP   = 7;
   localparam int A_RX_EMPTY = 8;
   localparam int A_DIV      = 9;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_EXEC,
      ST_XFER
   } seq_state_e;
endpackage

// File: rtl/spi_opseq_fifo.sv
module spi_opseq_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spi_opseq_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0] mem_q [DEPTH];
   logic [AW:0]  wptr_q, rptr_q;

   assign empty = (wptr_q == rptr_q);
   assign full  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
   assign rdata = mem_q[rptr_q[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push && !full) mem_q[wptr_q[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
      end else begin
         if (push && !full) wptr_q <= wptr_q + 1'b1;
         if (pop && !empty) rptr_q <= rptr_q + 1'b1;
      end
   end
endmodule

// File: rtl/spi_opseq_shifter.sv
module spi_opseq_shifter
   import spi_opseq_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div,
   input  logic              start,
   input  logic [BYTE_W-1:0] din,
   input  logic              miso,
   output logic              done,
   output logic [BYTE_W-1:0] dout,
   output logic              sclk,
   output logic              mosi
);
   localparam int BW = $clog2(BYTE_W);
   localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

   if (DIV_W < 1) begin : g_bad_div
      $error("spi_opseq_shifter: DIV_W must be at least 1");
   end

   logic              busy_q, sclk_q, done_q;
   logic [DIV_W-1:0]  cnt_q;
   logic [BW-1:0]     bit_q;
   logic [BYTE_W-1:0] tx_q, rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
         bit_q  <= '0;
         tx_q   <= '0;
         rx_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
            cnt_q  <= '0;
            bit_q  <= '0;
            tx_q   <= din;
         end else if (busy_q) begin
            if (cnt_q >= div) begin
               cnt_q <= '0;
               if (!sclk_q) begin
                  sclk_q <= 1'b1;
                  rx_q   <= {rx_q[BYTE_W-2:0], miso};
               end else begin
                  sclk_q <= 1'b0;
                  if (bit_q == LAST_BIT) begin
                     busy_q <= 1'b0;
                     done_q <= 1'b1;
                  end else begin
                     bit_q <= bit_q + 1'b1;
                     tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                  end
               end
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign sclk = sclk_q;
   assign mosi = tx_q[BYTE_W-1];
   assign done = done_q;
   assign dout = rx_q;
endmodule

// File: rtl/spi_opseq.sv
module spi_opseq
   import spi_opseq_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 4,
   parameter int OP_DEPTH = 8,
   parameter int TX_DEPTH = 16,
   parameter int RX_DEPTH = 16,
   parameter int DIV_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              spi_sclk,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              op_full,
   output logic              op_empty,
   output logic              tx_full,
   output logic              rx_empty
);
   localparam int OPW = OPC_W + LEN_W;

   if (DATA_W <= OPW || DIV_W > DATA_W) begin : g_bad_data_w
      $error("spi_opseq: DATA_W must exceed the op word and hold DIV_W");
   end
   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("spi_opseq: ADDR_W must be at least 4");
   end

   logic [OPW-1:0]    stage_q;
   logic [DIV_W-1:0]  div_q;
   logic [OPW-1:0]    op_head;
   logic              op_fifo_empty, op_pop, op_push;
   logic [BYTE_W-1:0] tx_head, rx_head, shf_din, shf_dout;
   logic              tx_empty, tx_push, tx_pop;
   logic              rx_full, rx_push, rx_pop;
   logic              shf_start, shf_done;
   seq_state_e        st_q;
   logic [OPC_W-1:0]  opc_q;
   logic [LEN_W-1:0]  len_q;
   logic              cs_n_q;
   logic              is_out, is_in;
   wire               unused_wdata = ^bus_wdata[DATA_W-1:OPW];

   function automatic logic hit(input int a);
      return bus_addr == ADDR_W'(a);
   endfunction

   assign op_push = bus_wr && hit(A_OP_PUSH) && bus_wdata[0];
   assign tx_push = bus_wr && hit(A_TX_DATA);
   assign rx_pop  = bus_wr && hit(A_RX_POP) && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q   <= '0;
         div_q     <= '0;
         bus_rdata <= '0;
      end else begin
         if (bus_wr && hit(A_OP_STAGE)) stage_q <= bus_wdata[OPW-1:0];
         if (bus_wr && hit(A_DIV))      div_q   <= bus_wdata[DIV_W-1:0];
         if (bus_rd) begin
            bus_rdata <= '0;
            case (int'(bus_addr))
               A_OP_FULL:  bus_rdata[0] <= op_full;
               A_OP_EMPTY: bus_rdata[0] <= op_empty;
               A_TX_FULL:  bus_rdata[0] <= tx_full;
               A_RX_DATA:  bus_rdata[BYTE_W-1:0] <= rx_head;
               A_RX_EMPTY: bus_rdata[0] <= rx_empty;
               A_DIV:      bus_rdata[DIV_W-1:0] <= div_q;
               default:    bus_rdata <= '0;
            endcase
         end
      end
   end

   spi_opseq_fifo #(.W(OPW), .DEPTH(OP_DEPTH)) i_op_fifo (
      .clk(clk), .rst_n(rst_n), .push(op_push), .wdata(stage_q),
      .pop(op_pop), .rdata(op_head), .full(op_full), .empty(op_fifo_empty));

   spi_opseq_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) i_tx_fifo (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata[BYTE_W-1:0]),
      .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty));

   spi_opseq_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) i_rx_fifo (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(shf_dout),
      .pop(rx_pop), .rdata(rx_head), .full(rx_full), .empty(rx_empty));

   spi_opseq_shifter #(.DIV_W(DIV_W)) i_shifter (
      .clk(clk), .rst_n(rst_n), .div(div_q), .start(shf_start), .din(shf_din),
      .miso(spi_miso), .done(shf_done), .dout(shf_dout),
      .sclk(spi_sclk), .mosi(spi_mosi));

   assign is_out = (opc_q == OPC_OUT) || (opc_q == OPC_OUT_ALT);
   assign is_in  = (opc_q == OPC_IN);

   always_comb begin
      op_pop    = (st_q == ST_IDLE) && !op_fifo_empty;
      tx_pop    = 1'b0;
      shf_start = 1'b0;
      shf_din   = '1;
      if (st_q == ST_EXEC && len_q != '0) begin
         if (is_out && !tx_empty) begin
            tx_pop    = 1'b1;
            shf_start = 1'b1;
            shf_din   = tx_head;
         end else if (is_in && !rx_full) begin
            shf_start = 1'b1;
         end
      end
   end

   assign rx_push = (st_q == ST_XFER) && shf_done && is_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         opc_q  <= '0;
         len_q  <= '0;
         cs_n_q <= 1'b1;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (op_pop) begin
                  opc_q <= op_head[OPW-1:LEN_W];
                  len_q <= op_head[LEN_W-1:0];
                  st_q  <= ST_EXEC;
               end
            end
            ST_EXEC: begin
               if (opc_q == OPC_CS_HIGH) begin
                  cs_n_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end else if (opc_q == OPC_CS_LOW) begin
                  cs_n_q <= 1'b0;
                  st_q   <= ST_IDLE;
               end else if ((is_out || is_in) && len_q != '0) begin
                  if (shf_start) st_q <= ST_XFER;
               end else begin
                  st_q <= ST_IDLE;
               end
            end
            ST_XFER: begin
               if (shf_done) begin
                  len_q <= len_q - 1'b1;
                  st_q  <= ST_EXEC;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign spi_cs_n = cs_n_q;
   assign op_empty = op_fifo_empty && (st_q == ST_IDLE);
endmodule

// File: rtl/spi_opseq_chk.sv
module spi_opseq_chk (
   input logic clk,
   input logic rst_n,
   input logic spi_sclk,
   input logic spi_mosi,
   input logic spi_cs_n,
   input logic op_empty,
   input logic rx_push,
   input logic rx_full,
   input logic tx_pop,
   input logic tx_empty
);
   p_mosi_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sclk) |-> $stable(spi_mosi));

   p_cs_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(spi_cs_n) |-> !spi_sclk);

   p_idle_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      op_empty |-> !spi_sclk);

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_push && rx_full));

   p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_pop && tx_empty));
endmodule

bind spi_opseq spi_opseq_chk i_chk (
   .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
   .spi_cs_n(spi_cs_n), .op_empty(op_empty), .rx_push(rx_push),
   .rx_full(rx_full), .tx_pop(tx_pop), .tx_empty(tx_empty));

// File: tb/test_spi_opseq.sv
module test_spi_opseq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;
   logic        op_full, op_empty, tx_full, rx_empty;

   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   spi_opseq i_spi_opseq (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .op_full(op_full), .op_empty(op_empty),
      .tx_full(tx_full), .rx_empty(rx_empty));

   // flash model: replies seed, seed+1, ... per byte; logs MOSI bytes
   logic [7:0] slv_seed = 8'h00;
   logic [7:0] slv_reply = 8'h00;
   logic [7:0] slv_cap = 8'h00;
   logic [7:0] slv_log [256];
   int         slv_n = 0;
   int         slv_bit = 0;
   int         sclk_rises = 0;

   always @(negedge spi_cs_n or posedge spi_sclk) begin
      if (spi_sclk) begin
         sclk_rises = sclk_rises + 1;
         slv_cap = {slv_cap[6:0], spi_mosi};
         if (slv_bit == 7) begin
            slv_log[slv_n[7:0]] = slv_cap;
            slv_n = slv_n + 1;
            slv_bit = 0;
            slv_reply = slv_reply + 8'h01;
         end else begin
            slv_bit = slv_bit + 1;
         end
      end else begin
         slv_reply = slv_seed;
         slv_bit = 0;
      end
   end
   assign spi_miso = slv_reply[7 - slv_bit];

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 16'(d);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 4'(a);
      @(negedge clk);
      bus_rd = 1'b0;
      d = int'(bus_rdata);
   endtask

   task automatic op(input int opc, input int len);
      wr(0, (opc << 9) | len);
      wr(1, 1);
   endtask

   task automatic wait_done();
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (op_empty) break;
      end
   endtask

   // vector: div, tx count, tx first byte, rx count, reply seed
   localparam logic [39:0] VEC [4] = '{
      {8'd0, 8'd3, 8'h9F, 8'd3, 8'hC2},
      {8'd1, 8'd1, 8'h0F, 8'd1, 8'h81},
      {8'd2, 8'd4, 8'h13, 8'd0, 8'h00},
      {8'd0, 8'd0, 8'h00, 8'd5, 8'h7E}
   };

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int v, base, r0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 cs_n", int'(spi_cs_n), 1);
      chk("R1 sclk", int'(spi_sclk), 0);
      chk("R1 op_empty", int'(op_empty), 1);
      chk("R1 op_full", int'(op_full), 0);
      chk("R1 tx_full", int'(tx_full), 0);
      chk("R1 rx_empty", int'(rx_empty), 1);
      rst_n = 1'b1;
      @(negedge clk);
      rd(3, v); chk("R2 empty reg", v, 1);

      // vector walk: R2 R3 R4 R5 R6 R7
      for (int k = 0; k < 4; k++) begin
         logic [7:0] dv, ntx, tx0, nrx, sd;
         {dv, ntx, tx0, nrx, sd} = VEC[k];
         slv_seed = sd;
         wr(9, int'(dv));
         base = slv_n;
         for (int i = 0; i < int'(ntx); i++) wr(4, int'(8'(tx0 + 8'(i * 17))));
         op(1, 1);
         op((k == 1) ? 5'h11 : 5'h08, int'(ntx));
         op(5'h0C, int'(nrx));
         op(0, 1);
         wait_done();
         chk("R7 op_empty done", int'(op_empty), 1);
         chk("R3 cs_n released", int'(spi_cs_n), 1);
         chk("R4 R5 byte count", slv_n - base, int'(ntx) + int'(nrx));
         for (int i = 0; i < int'(ntx); i++)
            chk("R4 mosi byte", int'(slv_log[8'(base + i)]), int'(8'(tx0 + 8'(i * 17))));
         for (int i = 0; i < int'(nrx); i++) begin
            chk("R5 mosi high", int'(slv_log[8'(base + int'(ntx) + i)]), 8'hFF);
            rd(6, v);
            chk("R6 rx byte", v, int'(8'(sd + ntx + 8'(i))));
            wr(7, 1);
         end
         rd(8, v); chk("R6 rx empty reg", v, 1);
      end

      // R9 phase length with DIV=3
      wr(9, 3);
      op(1, 1);
      base = slv_n;
      wr(4, 8'hA5);
      op(8, 1);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (spi_sclk) break;
      end
      v = 0;
      while (spi_sclk && v < 50) begin v++; @(negedge clk); end
      chk("R9 high phase", v, 4);
      v = 0;
      while (!spi_sclk && v < 50) begin v++; @(negedge clk); end
      chk("R9 low phase", v, 4);
      wait_done();
      chk("R4 byte A5", int'(slv_log[8'(base)]), 8'hA5);
      wr(9, 0);

      // R8 output stall, R7 flag while stalled
      base = slv_n;
      r0 = sclk_rises;
      op(8, 2);
      repeat (40) @(negedge clk);
      chk("R8 tx stall no clock", sclk_rises - r0, 0);
      chk("R7 busy while stalled", int'(op_empty), 0);
      wr(4, 8'h3C); wr(4, 8'hC3);
      wait_done();
      chk("R8 resume count", slv_n - base, 2);
      chk("R8 resume byte", int'(slv_log[8'(base + 1)]), 8'hC3);

      // R10 zero count and unknown opcode
      r0 = sclk_rises;
      op(8, 0);
      op(5'h1F, 3);
      op(5'h0C, 0);
      wait_done();
      chk("R10 no clock", sclk_rises - r0, 0);
      chk("R10 cs unchanged", int'(spi_cs_n), 0);

      // R11 tx full drop
      base = slv_n;
      for (int i = 0; i < 17; i++) wr(4, 8'h40 + i);
      chk("R11 tx_full", int'(tx_full), 1);
      rd(5, v); chk("R11 tx full reg", v, 1);
      op(8, 16);
      wait_done();
      chk("R11 tx_full clear", int'(tx_full), 0);
      chk("R11 first bytes", int'(slv_log[8'(base + 15)]), 8'h4F);
      op(8, 1);
      repeat (30) @(negedge clk);
      chk("R11 17th dropped", int'(op_empty), 0);
      wr(4, 8'h99);
      wait_done();
      chk("R11 new byte", int'(slv_log[8'(base + 16)]), 8'h99);

      // R11 op FIFO full drop
      base = slv_n;
      op(8, 1);
      for (int i = 0; i < 8; i++) op(8, 0);
      chk("R11 op_full", int'(op_full), 1);
      rd(2, v); chk("R2 full reg", v, 1);
      op(0, 1);
      wr(4, 8'h5A);
      wait_done();
      chk("R11 dropped cs op", int'(spi_cs_n), 0);
      chk("R11 op count", slv_n - base, 1);
      op(0, 1);
      wait_done();

      // R8 input stall on full receive FIFO, R6 pop
      slv_seed = 8'h20;
      op(1, 1);
      op(5'h0C, 17);
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (slv_n != 0 && sclk_rises % 8 == 0 && i > 3000) break;
      end
      chk("R8 rx stall busy", int'(op_empty), 0);
      chk("R8 rx stall sclk low", int'(spi_sclk), 0);
      rd(6, v); chk("R6 head", v, 8'h20);
      wr(7, 1);
      wait_done();
      for (int i = 0; i < 16; i++) begin
         rd(6, v);
         chk("R8 rx kept", v, 8'h21 + i);
         wr(7, 1);
      end
      chk("R6 rx_empty", int'(rx_empty), 1);
      op(0, 1);
      wait_done();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule